// File: doc/BRIEF.md
# SPI Slave Receive Buffer with Overflow Detection

This block is the receive half of an 8-bit SPI slave. It shifts in serial data on the rising edge of the serial clock while slave select is low, most significant bit first. After the eighth bit it moves the byte into a receive data register and raises a receiver-full flag. The serial clock, slave select and data input are synchronised into the system clock domain, and all edges are detected there. The system clock must run at least four times faster than the serial clock.

Overflow is decided early, at the sampling edge of the seventh bit, which is the bit one position above the least significant bit. If the previous byte is still unread at that edge, the overflow flag is set. From then on every completed byte is dropped. The earlier byte stays readable until the flag is cleared.

A mode-fault flag reports a byte that slave select cut short. Each flag is cleared by a two-step sequence: a status read that returns the flag set, then a data read. The three flags drive one shared interrupt line.

Top module: `spi_rx_buffer`

## Requirements
- R1: After reset, `stat_rdata` and `data_rdata` are zero and `irq` is low. The status layout is: [7] receiver-full, [6] overflow, [5] mode-fault, [4:3] zero, [2] mode-fault enable, [1] error-interrupt enable, [0] receive-interrupt enable. A control write loads bits [2:0] from `ctrl_wdata[2:0]`.
- R2: A complete 8-bit frame is received MSB first. If neither flag blocks it, the byte is loaded into the data register and receiver-full is set.
- R3: Overflow is set at the 7th sampling edge of a frame when receiver-full is set. This also applies to a frame that is cut off after its 7th bit.
- R4: While overflow is set, a completed frame is discarded. The data register stays unchanged and receiver-full is not set.
- R5: A data read clears a flag only if the last status read returned that flag set and no control write came in between. A data read without such a status read clears nothing.
- R6: If overflow becomes set after a status read that showed receiver-full, the following data read clears receiver-full, and overflow stays set.
- R7: `irq` = (receiver-full AND receive-interrupt enable) OR (error-interrupt enable AND (overflow OR mode-fault)).
- R8: Mode-fault is set when slave select rises partway through a frame, and only while the mode-fault enable is high. It is cleared by the same two-step sequence as the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| ss_n_in | input | 1 | Slave select, active low, asynchronous |
| sdata_in | input | 1 | Serial data input |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control write data; only [2:0] are used |
| stat_rdata | output | 8 | Status register contents |
| data_rdata | output | 8 | Receive data register contents |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions assume two things about the inputs. The CPU never issues a status read and a data read in the same cycle. Serial edges are far enough apart that each one is seen by the synchroniser. The stimulus holds every serial level for four system clocks and issues register accesses only while the serial line is idle. Random frames, aborted frames of every length, reads and control writes are mixed in any order, so the overflow freeze and the arming rules are reached from many different flag states.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int ENB_W  = 3;

    typedef struct packed {
        logic full;
        logic ovf;
        logic modf;
    } rx_flags_t;

    typedef struct packed {
        logic mf_en;
        logic err_ie;
        logic rx_ie;
    } rx_ctrl_t;

    function automatic logic [DATA_W-1:0] pack_status(rx_flags_t f, rx_ctrl_t c);
        logic [DATA_W-1:0] s;
        s = '0;
        s[7] = f.full;
        s[6] = f.ovf;
        s[5] = f.modf;
        s[2:0] = c;
        return s;
    endfunction

    function automatic logic irq_of(rx_flags_t f, rx_ctrl_t c);
        return (f.full & c.rx_ie) | (c.err_ie & (f.ovf | f.modf));
    endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= rst_val;
                else if (s == 0) pipe[s] <= async_in;
                else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              ss_n_s,
    input  logic              sdata_s,
    output logic              bit1_stb,
    output logic              byte_done,
    output logic              abort,
    output logic [DATA_W-1:0] byte_out
);
    localparam logic [CNT_W-1:0] BIT1_CNT = CNT_W'(DATA_W - 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    logic              sclk_q, ss_n_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              sample;

    assign sample    = sclk_s & ~sclk_q & ~ss_n_s;
    assign bit1_stb  = sample && (cnt == BIT1_CNT);
    assign byte_done = sample && (cnt == LAST_CNT);
    assign byte_out  = {shreg[DATA_W-2:0], sdata_s};
    assign abort     = ss_n_s & ~ss_n_q & (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            ss_n_q <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
        end else begin
            sclk_q <= sclk_s;
            ss_n_q <= ss_n_s;
            if (ss_n_s) begin
                cnt <= '0;
            end else if (sample) begin
                shreg <= byte_out;
                cnt   <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ctrl_wr,
    input  logic [ENB_W-1:0]  ctrl_wdata,
    input  logic              bit1_stb,
    input  logic              byte_done,
    input  logic              abort,
    input  logic [DATA_W-1:0] byte_in,
    output rx_flags_t         flags_q,
    output rx_ctrl_t          ctrl_q,
    output logic [DATA_W-1:0] data_q
);
    rx_flags_t         flags_n, armed_q, armed_n;
    logic [DATA_W-1:0] data_n;

    always_comb begin
        flags_n = flags_q;
        armed_n = armed_q;
        data_n  = data_q;
        if (ctrl_wr) armed_n = '0;
        if (stat_rd) armed_n = flags_q;
        if (data_rd) begin
            if (armed_q.full) flags_n.full = 1'b0;
            if (armed_q.ovf)  flags_n.ovf  = 1'b0;
            if (armed_q.modf) flags_n.modf = 1'b0;
            armed_n = '0;
        end
        if (bit1_stb && flags_q.full) flags_n.ovf = 1'b1;
        if (byte_done && !flags_q.ovf) begin
            data_n       = byte_in;
            flags_n.full = 1'b1;
        end
        if (abort && ctrl_q.mf_en) flags_n.modf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            armed_q <= '0;
            ctrl_q  <= '0;
            data_q  <= '0;
        end else begin
            flags_q <= flags_n;
            armed_q <= armed_n;
            data_q  <= data_n;
            if (ctrl_wr) ctrl_q <= rx_ctrl_t'(ctrl_wdata);
        end
    end
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              ss_n_in,
    input  logic              sdata_in,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic [DATA_W-1:0] stat_rdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              irq
);
    logic [2:0]        sync_o;
    logic              bit1_stb, byte_done, abort;
    logic [DATA_W-1:0] byte_w, data_q;
    rx_flags_t         flags_q;
    rx_ctrl_t          ctrl_q;
    logic [DATA_W-ENB_W-1:0] unused_wdata;

    assign unused_wdata = ctrl_wdata[DATA_W-1:ENB_W];

    spi_rx_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .async_in({sclk_in, ss_n_in, sdata_in}),
        .rst_val(3'b010),
        .sync_out(sync_o)
    );

    spi_rx_shifter u_shift (
        .clk(clk), .rst(rst),
        .sclk_s(sync_o[2]), .ss_n_s(sync_o[1]), .sdata_s(sync_o[0]),
        .bit1_stb(bit1_stb), .byte_done(byte_done), .abort(abort),
        .byte_out(byte_w)
    );

    spi_rx_flags u_flags (
        .clk(clk), .rst(rst),
        .stat_rd(stat_rd), .data_rd(data_rd), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata[ENB_W-1:0]),
        .bit1_stb(bit1_stb), .byte_done(byte_done), .abort(abort),
        .byte_in(byte_w),
        .flags_q(flags_q), .ctrl_q(ctrl_q), .data_q(data_q)
    );

    assign stat_rdata = pack_status(flags_q, ctrl_q);
    assign data_rdata = data_q;
    assign irq        = irq_of(flags_q, ctrl_q);
endmodule

// File: rtl/spi_rx_buffer_chk.sv
module spi_rx_buffer_chk
    import spi_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              data_rd,
    input logic              bit1_stb,
    input logic              irq,
    input rx_flags_t         flags_q,
    input rx_ctrl_t          ctrl_q,
    input logic [DATA_W-1:0] data_q
);
    // R3
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.ovf) |-> ($past(flags_q.full) && $past(bit1_stb)));
    // R4
    frozen_data_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flags_q.ovf) |-> $stable(data_q));
    // R4
    no_full_in_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flags_q.ovf) && !$past(flags_q.full)) |-> !flags_q.full);
    // R5
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.ovf) |-> $past(data_rd));
    // R5
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.full) |-> $past(data_rd));
    // R8
    modf_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.modf) |-> $past(ctrl_q.mf_en));
    // R7
    irq_err_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.err_ie && (flags_q.ovf || flags_q.modf)) |-> irq);
endmodule

bind spi_rx_buffer spi_rx_buffer_chk u_chk (
    .clk(clk), .rst(rst), .data_rd(data_rd), .bit1_stb(bit1_stb),
    .irq(irq), .flags_q(flags_q), .ctrl_q(ctrl_q), .data_q(data_q)
);

// File: tb/tb_spi_rx_buffer.sv
module tb_spi_rx_buffer;
    logic clk = 1'b0, rst = 1'b1;
    logic sclk_in = 1'b0, ss_n_in = 1'b1, sdata_in = 1'b0;
    logic stat_rd = 1'b0, data_rd = 1'b0, ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] stat_rdata, data_rdata;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    bit m_full, m_ovf, m_modf, a_full, a_ovf, a_modf;
    logic [2:0] m_en;
    logic [7:0] m_data;

    always #4 clk = ~clk;

    spi_rx_buffer dut (.*);

    function automatic logic [7:0] exp_status();
        return {m_full, m_ovf, m_modf, 2'b00, m_en};
    endfunction

    function automatic logic exp_irq();
        return (m_full & m_en[0]) | (m_en[1] & (m_ovf | m_modf));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(posedge clk);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        @(negedge clk) ss_n_in = 1'b0;
        half();
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sdata_in = b[7-i];
            half();
            @(negedge clk) sclk_in = 1'b1;
            half();
            @(negedge clk) sclk_in = 1'b0;
            if (i == 6 && m_full) m_ovf = 1;
        end
        half();
        @(negedge clk) ss_n_in = 1'b1;
        repeat (8) @(posedge clk);
        if (n == 8) begin
            if (!m_ovf) begin m_data = b; m_full = 1; end
        end else if (m_en[2]) m_modf = 1;
    endtask

    task automatic status_read(string req);
        @(negedge clk) stat_rd = 1'b1;
        #1 chk(req, stat_rdata, exp_status());
        chk("R7", irq, exp_irq());
        a_full = m_full; a_ovf = m_ovf; a_modf = m_modf;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic data_read(string req);
        @(negedge clk) data_rd = 1'b1;
        #1 chk(req, data_rdata, m_data);
        if (a_full) m_full = 0;
        if (a_ovf)  m_ovf  = 0;
        if (a_modf) m_modf = 0;
        a_full = 0; a_ovf = 0; a_modf = 0;
        @(negedge clk) data_rd = 1'b0;
    endtask

    task automatic ctrl_write(logic [7:0] v);
        @(negedge clk) ctrl_wr = 1'b1; ctrl_wdata = v;
        m_en = v[2:0]; a_full = 0; a_ovf = 0; a_modf = 0;
        @(negedge clk) ctrl_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_en = '0; m_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 status", stat_rdata, 8'h00);
        chk("R1 data", data_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);

        ctrl_write(8'hFF);
        status_read("R1 layout");
        // R2: receipt, then two-step clear
        send_bits(8'hA5, 8);
        status_read("R2 full");
        data_read("R2 data");
        status_read("R5 cleared");
        // R5: data read without status read clears nothing
        send_bits(8'h3C, 8);
        data_read("R5 unarmed");
        status_read("R5 still full");
        data_read("R5 data");
        // R3/R4: overflow and discard
        send_bits(8'h11, 8);
        send_bits(8'h22, 8);
        status_read("R3 ovf set");
        send_bits(8'h33, 8);
        status_read("R4 frozen");
        data_read("R4 old byte");
        status_read("R4 cleared");
        // R6: overflow arises between the two reads
        send_bits(8'h44, 8);
        status_read("R6 full only");
        send_bits(8'h55, 8);
        data_read("R6 data");
        status_read("R6 ovf stays");
        send_bits(8'h66, 8);
        status_read("R4 full not set");
        data_read("R6 clear");
        status_read("R6 clean");
        // R5: control write disarms
        send_bits(8'h77, 8);
        status_read("R5 arm");
        ctrl_write(8'h07);
        data_read("R5 disarmed");
        status_read("R5 full kept");
        status_read("R5 rearm");
        data_read("R5 data");
        // R3: a 7-bit frame still flags overflow
        send_bits(8'h88, 8);
        send_bits(8'hF0, 7);
        status_read("R3 partial ovf");
        data_read("R3 data");
        // R8: mode fault
        send_bits(8'hC3, 3);
        status_read("R8 modf set");
        data_read("R8 data");
        status_read("R8 modf clear");
        ctrl_write(8'h03);
        send_bits(8'hC3, 5);
        status_read("R8 disabled");

        for (int k = 0; k < 150; k++) begin
            case ($urandom_range(0, 5))
                0, 1: send_bits(8'($urandom), 8);
                2: send_bits(8'($urandom), $urandom_range(1, 7));
                3: status_read("R5 random status");
                4: data_read("R2 random data");
                default: ctrl_write(8'($urandom));
            endcase
        end
        status_read("R7 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule